// File: doc/BRIEF.md
# DMA Operand Address Sequencer

This block produces the address and byte-lane pattern for every bus cycle of one DMA channel. Each start command carries a configuration and a count of operands. The configuration gives the device port width (8 or 16 bits), the operand size (byte, word or longword), a count mode for the memory pointer, a count mode for the device pointer, and a flag that selects single-address or dual-address operation. The block then walks through the operands one by one. An operand wider than the port takes several bus cycles. Each cycle is held on the bus until the bus acknowledges it.

In single-address operation only the memory pointer drives the bus, and each operand takes exactly one cycle. In dual-address operation every operand is first read from memory in one or more pieces and then written to the device in the same number of pieces. The pieces of an operand always climb in address, two apart, whichever way the pointer counts. The pointers and the operand counter change only once an operand has fully moved. A configuration that cannot work in single-address mode is refused with an error flag.

Top module: `dma_opseq`

## Requirements
- R1: The number of bus cycles per operand in each phase is the operand byte count divided by the port byte count, with a minimum of one. Operand size codes are 0 byte (1 byte), 1 word (2 bytes), 2 and 3 longword (4 bytes). `cfg_port16`=1 selects a 16-bit port and 0 selects an 8-bit port.
- R2: Piece k of an operand (k counting from 0) is addressed at the phase base pointer plus 2*k. Pieces are issued in increasing k, whatever the count mode.
- R3: In single-address mode (`cfg_dual`=0), each operand is one cycle at the memory pointer, with `bus_dev`=0. The memory pointer step is 1 for a byte operand and 2 for a word operand.
- R4: After an operand completes, each active pointer moves by the operand byte count (1, 2 or 4) according to its own mode. Mode code 1 adds, code 2 subtracts, and codes 0 and 3 leave the pointer unchanged. The device pointer changes only in dual-address mode.
- R5: In dual-address mode, each operand issues all of its memory pieces (`bus_dev`=0) and then all of its device pieces (`bus_dev`=1).
- R6: `bus_be` is 2'b11 when the port is 16 bits wide and the operand is wider than a byte. Otherwise it selects one lane from address bit 0: 2'b01 when the bit is 0, 2'b10 when it is 1.
- R7: `xfer_left` loads with `init_count` on an accepted start and then falls by one per completed operand.
- R8: After the acknowledge of the last operand, `done` is high for exactly one cycle while `busy` is low. A start with a count of zero gives that pulse in the next cycle and issues no bus cycle.
- R9: In single-address mode, a start whose port width and operand size differ sets `cfg_err`, issues no bus cycle and leaves the block idle. The next accepted start clears `cfg_err`.
- R10: While `bus_req` is high and `bus_ack` is low, the address, byte enables and `bus_dev` hold steady. A new cycle begins only after an acknowledge.
- R11: After reset, `busy`, `bus_req`, `done`, `cfg_err` and `xfer_left` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run with the presented configuration (sampled while idle) |
| cfg_dual | input | 1 | 1 = dual-address, 0 = single-address |
| cfg_port16 | input | 1 | 1 = 16-bit port, 0 = 8-bit port |
| cfg_opsz | input | 2 | Operand size code |
| cfg_mem_mode | input | 2 | Memory pointer count mode |
| cfg_dev_mode | input | 2 | Device pointer count mode |
| init_mem_addr | input | AW | Starting memory pointer |
| init_dev_addr | input | AW | Starting device pointer |
| init_count | input | CW | Number of operands |
| bus_ack | input | 1 | Acknowledge of the current bus cycle |
| bus_req | output | 1 | Bus cycle pending |
| bus_addr | output | AW | Address of the current cycle |
| bus_be | output | 2 | Byte lanes of the current cycle |
| bus_dev | output | 1 | 1 when the cycle targets the device side |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| cfg_err | output | 1 | Last start was refused |
| mem_addr | output | AW | Current memory pointer |
| dev_addr | output | AW | Current device pointer |
| xfer_left | output | CW | Operands still to move |

## Verification
The properties assume that `bus_ack` is only meaningful while `bus_req` is high. They also assume that software keeps the starting pointers aligned so that a two-lane cycle never falls on an odd address. The bench acknowledges only pending cycles and inserts a wait state on every other cycle. It uses even pointers for all word and longword runs on a 16-bit port and uses odd pointers only where a single lane is expected. It raises `start` only while the block is idle, so no start arrives during a run.

// File: rtl/dma_opseq_pkg.sv
package dma_opseq_pkg;

    typedef enum logic [1:0] {
        OPSZ_BYTE = 2'd0,
        OPSZ_WORD = 2'd1,
        OPSZ_LONG = 2'd2,
        OPSZ_LNG2 = 2'd3
    } opsz_e;

    typedef enum logic [1:0] {
        CNT_HOLD  = 2'd0,
        CNT_INC   = 2'd1,
        CNT_DEC   = 2'd2,
        CNT_HOLD2 = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEM  = 2'd1,
        ST_DEV  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic      dual;
        logic      port16;
        opsz_e     opsz;
        cnt_mode_e mem_mode;
        cnt_mode_e dev_mode;
    } seq_cfg_t;

    // Bytes carried by one operand.
    function automatic logic [2:0] op_bytes(opsz_e s);
        case (s)
            OPSZ_BYTE: return 3'd1;
            OPSZ_WORD: return 3'd2;
            default:   return 3'd4;
        endcase
    endfunction

    // Bus cycles needed per operand in one phase.
    function automatic logic [2:0] part_count(logic port16, opsz_e s);
        logic [2:0] b;
        b = op_bytes(s);
        if (port16 && b > 3'd1) return b >> 1;
        return b;
    endfunction

    // Single-address mode needs port width equal to operand size.
    function automatic logic size_match(logic port16, opsz_e s);
        return port16 ? (s == OPSZ_WORD) : (s == OPSZ_BYTE);
    endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_opseq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr_i,
    input  cnt_mode_e     mode_i,
    input  logic [2:0]    nbytes_i,
    output logic [AW-1:0] addr_o
);
    logic [AW-1:0] step;

    always_comb begin
        step = AW'(nbytes_i);
        case (mode_i)
            CNT_INC: addr_o = addr_i + step;
            CNT_DEC: addr_o = addr_i - step;
            default: addr_o = addr_i;
        endcase
    end
endmodule

// File: rtl/dma_part_ctr.sv
module dma_part_ctr #(
    parameter int MAX_PARTS = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr_i,
    input  logic                       adv_i,
    input  logic [$clog2(MAX_PARTS):0] nparts_i,
    output logic [$clog2(MAX_PARTS)-1:0] idx_o,
    output logic                       last_o
);
    localparam int IW = $clog2(MAX_PARTS);

    logic [IW-1:0] idx_q;

    assign last_o = ({1'b0, idx_q} == (nparts_i - (IW+1)'(1)));
    assign idx_o  = idx_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            idx_q <= '0;
        end else if (adv_i) begin
            idx_q <= last_o ? '0 : idx_q + IW'(1);
        end
    end
endmodule

// File: rtl/dma_opseq.sv
module dma_opseq
    import dma_opseq_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          cfg_dual,
    input  logic          cfg_port16,
    input  logic [1:0]    cfg_opsz,
    input  logic [1:0]    cfg_mem_mode,
    input  logic [1:0]    cfg_dev_mode,
    input  logic [AW-1:0] init_mem_addr,
    input  logic [AW-1:0] init_dev_addr,
    input  logic [CW-1:0] init_count,
    input  logic          bus_ack,
    output logic          bus_req,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_be,
    output logic          bus_dev,
    output logic          busy,
    output logic          done,
    output logic          cfg_err,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] dev_addr,
    output logic [CW-1:0] xfer_left
);
    localparam int MAX_PARTS = 4;
    localparam int IW        = $clog2(MAX_PARTS);

    seq_state_e    state_q;
    seq_cfg_t      cfg_q, cfg_in;
    logic [AW-1:0] mem_q, dev_q, mem_next, dev_next, base;
    logic [CW-1:0] cnt_q;
    logic          done_q, err_q;

    logic [IW:0]   nparts;
    logic [2:0]    nbytes;
    logic [IW-1:0] part_idx;
    logic          part_last;
    logic          xfer_ack, accept, op_end;

    assign cfg_in = '{dual: cfg_dual, port16: cfg_port16, opsz: opsz_e'(cfg_opsz),
                      mem_mode: cnt_mode_e'(cfg_mem_mode),
                      dev_mode: cnt_mode_e'(cfg_dev_mode)};

    always_comb begin
        nbytes   = op_bytes(cfg_q.opsz);
        nparts   = (IW+1)'(part_count(cfg_q.port16, cfg_q.opsz));
        busy     = (state_q != ST_IDLE);
        xfer_ack = busy && bus_ack;
        accept   = (state_q == ST_IDLE) && start &&
                   (cfg_in.dual || size_match(cfg_in.port16, cfg_in.opsz));
        op_end   = xfer_ack && part_last &&
                   ((state_q == ST_DEV) || !cfg_q.dual);
        base     = (state_q == ST_DEV) ? dev_q : mem_q;
    end

    dma_part_ctr #(.MAX_PARTS(MAX_PARTS)) u_part (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (accept),
        .adv_i    (xfer_ack),
        .nparts_i (nparts),
        .idx_o    (part_idx),
        .last_o   (part_last)
    );

    dma_addr_step #(.AW(AW)) u_mem_step (
        .addr_i   (mem_q),
        .mode_i   (cfg_q.mem_mode),
        .nbytes_i (nbytes),
        .addr_o   (mem_next)
    );

    dma_addr_step #(.AW(AW)) u_dev_step (
        .addr_i   (dev_q),
        .mode_i   (cfg_q.dev_mode),
        .nbytes_i (nbytes),
        .addr_o   (dev_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            mem_q   <= '0;
            dev_q   <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start && !accept) begin
                        err_q <= 1'b1;
                    end else if (accept) begin
                        err_q <= 1'b0;
                        cfg_q <= cfg_in;
                        mem_q <= init_mem_addr;
                        dev_q <= init_dev_addr;
                        cnt_q <= init_count;
                        if (init_count == '0) done_q  <= 1'b1;
                        else                  state_q <= ST_MEM;
                    end
                end
                ST_MEM: begin
                    if (xfer_ack && part_last && cfg_q.dual) state_q <= ST_DEV;
                end
                ST_DEV: begin
                    if (xfer_ack && part_last) state_q <= ST_MEM;
                end
                default: state_q <= ST_IDLE;
            endcase

            if (op_end) begin
                mem_q <= mem_next;
                if (cfg_q.dual) dev_q <= dev_next;
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        bus_req  = busy;
        bus_addr = base + AW'({part_idx, 1'b0});
        bus_dev  = (state_q == ST_DEV);
        if (cfg_q.port16 && nbytes > 3'd1) bus_be = 2'b11;
        else                               bus_be = bus_addr[0] ? 2'b10 : 2'b01;
    end

    assign done      = done_q;
    assign cfg_err   = err_q;
    assign mem_addr  = mem_q;
    assign dev_addr  = dev_q;
    assign xfer_left = cnt_q;
endmodule

// File: rtl/dma_opseq_chk.sv
module dma_opseq_chk #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_ack,
    input logic          bus_req,
    input logic [AW-1:0] bus_addr,
    input logic [1:0]    bus_be,
    input logic          bus_dev,
    input logic          busy,
    input logic          done,
    input logic          cfg_err,
    input logic [CW-1:0] xfer_left
);
    // R10
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_be) && $stable(bus_dev));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R9
    err_no_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !bus_req);

    // R7
    count_by_one_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && xfer_left != $past(xfer_left))
            |-> xfer_left == $past(xfer_left) - CW'(1));

    // R6
    lane_present_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> $countones(bus_be) >= 1);
endmodule

bind dma_opseq dma_opseq_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_ack   (bus_ack),
    .bus_req   (bus_req),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_dev   (bus_dev),
    .busy      (busy),
    .done      (done),
    .cfg_err   (cfg_err),
    .xfer_left (xfer_left)
);

// File: tb/tb_dma_opseq.sv
module tb_dma_opseq;
    localparam int AW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          cfg_dual = 1'b0, cfg_port16 = 1'b0;
    logic [1:0]    cfg_opsz = '0, cfg_mem_mode = '0, cfg_dev_mode = '0;
    logic [AW-1:0] init_mem_addr = '0, init_dev_addr = '0;
    logic [CW-1:0] init_count = '0;
    logic          bus_ack = 1'b0;
    logic          bus_req, bus_dev, busy, done, cfg_err;
    logic [AW-1:0] bus_addr, mem_addr, dev_addr;
    logic [1:0]    bus_be;
    logic [CW-1:0] xfer_left;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [1:0]    be;
        logic          dev;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad   = 0;
    int   cyc   = 0;
    logic finished = 1'b0;

    always #10 clk = ~clk;

    dma_opseq #(.AW(AW), .CW(CW)) dut (.*);

    task automatic chk(input logic ok, input string tag, input logic [AW-1:0] act,
                       input logic [AW-1:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            summary();
        end
    end

    // Monitor: acknowledges every other pending cycle and scores it.
    initial begin
        bit stall = 1'b0;
        forever begin
            @(negedge clk);
            bus_ack = 1'b0;
            if (!rst && bus_req) begin
                stall = ~stall;
                if (!stall) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R10 unexpected bus cycle", bus_addr, '0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk(bus_addr == e.addr, "R2 R3 part address", bus_addr, e.addr);
                        chk(bus_be == e.be, "R6 byte lanes", AW'(bus_be), AW'(e.be));
                        chk(bus_dev == e.dev, "R5 phase side", AW'(bus_dev), AW'(e.dev));
                    end
                    bus_ack = 1'b1;
                end
            end
        end
    end

    function automatic int nbytes_of(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [AW-1:0] step_of(input logic [AW-1:0] a, input logic [1:0] m,
                                              input int nb);
        if (m == 2'd1) return a + AW'(nb);
        if (m == 2'd2) return a - AW'(nb);
        return a;
    endfunction

    function automatic logic [1:0] be_of(input logic p16, input int nb, input logic [AW-1:0] a);
        if (p16 && nb > 1) return 2'b11;
        return a[0] ? 2'b10 : 2'b01;
    endfunction

    task automatic run_op(input logic dual, input logic p16, input logic [1:0] sz,
                          input logic [1:0] mm, input logic [1:0] dm,
                          input logic [AW-1:0] ma, input logic [AW-1:0] da, input int n);
        int nb, np, waited;
        logic [AW-1:0] m, d;
        logic got;
        nb = nbytes_of(sz);
        np = dual ? ((p16 && nb > 1) ? nb / 2 : nb) : 1;   // R1
        m = ma; d = da;
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < np; k++)
                exp_q.push_back('{addr: m + AW'(2*k), be: be_of(p16, nb, m + AW'(2*k)), dev: 1'b0});
            if (dual)
                for (int k = 0; k < np; k++)
                    exp_q.push_back('{addr: d + AW'(2*k), be: be_of(p16, nb, d + AW'(2*k)), dev: 1'b1});
            m = step_of(m, mm, nb);
            if (dual) d = step_of(d, dm, nb);
        end
        @(negedge clk);
        cfg_dual = dual; cfg_port16 = p16; cfg_opsz = sz;
        cfg_mem_mode = mm; cfg_dev_mode = dm;
        init_mem_addr = ma; init_dev_addr = da; init_count = CW'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R7 counter loaded
        chk(xfer_left == CW'(n), "R7 count load", AW'(xfer_left), AW'(n));
        got = done;
        waited = 0;
        while (!got && waited < 5000) begin
            @(negedge clk);
            got = done;
            waited++;
        end
        chk(got, "R8 done seen", AW'(got), 1);
        chk(!busy, "R8 idle at done", AW'(busy), 0);
        chk(exp_q.size() == 0, "R1 all cycles issued", AW'(exp_q.size()), 0);
        chk(mem_addr == m, "R4 final memory pointer", mem_addr, m);
        chk(dev_addr == d, "R4 final device pointer", dev_addr, d);
        chk(xfer_left == '0, "R7 count exhausted", AW'(xfer_left), 0);
        chk(!cfg_err, "R9 error clear after good start", AW'(cfg_err), 0);
        @(negedge clk);
        chk(!done, "R8 done one cycle", AW'(done), 0);
        exp_q.delete();
    endtask

    task automatic run_bad(input logic p16, input logic [1:0] sz);
        @(negedge clk);
        cfg_dual = 1'b0; cfg_port16 = p16; cfg_opsz = sz;
        init_count = CW'(3);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(!bus_req, "R9 no cycle on bad size", AW'(bus_req), 0);
        end
        chk(cfg_err, "R9 error flag", AW'(cfg_err), 1);
        chk(!busy, "R9 stays idle", AW'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11
        chk(!busy && !bus_req, "R11 reset idle", AW'(busy), 0);
        chk(!done && !cfg_err, "R11 reset flags", AW'({done, cfg_err}), 0);
        chk(xfer_left == '0, "R11 reset count", AW'(xfer_left), 0);

        // R3 R4: single-address byte counting up, word counting down, byte fixed
        run_op(1'b0, 1'b0, 2'd0, 2'd1, 2'd0, 32'h100, 32'h0, 3);
        run_op(1'b0, 1'b1, 2'd1, 2'd2, 2'd0, 32'h200, 32'h0, 2);
        run_op(1'b0, 1'b0, 2'd0, 2'd0, 2'd1, 32'h155, 32'h40, 2);
        // R9: mismatched single-address sizes
        run_bad(1'b0, 2'd1);
        run_bad(1'b1, 2'd2);
        // R2 R5: dual longword, 16-bit port, memory down, device up
        run_op(1'b1, 1'b1, 2'd2, 2'd2, 2'd1, 32'h400, 32'h800, 2);
        // R1 R6: dual longword, 8-bit port, four pieces, odd device side
        run_op(1'b1, 1'b0, 2'd2, 2'd1, 2'd2, 32'h1000, 32'h2001, 2);
        // R6: dual byte on 16-bit port, single lane by address bit
        run_op(1'b1, 1'b1, 2'd0, 2'd1, 2'd1, 32'h301, 32'h500, 2);
        // R4: dual word, memory fixed, device down, longword code 3
        run_op(1'b1, 1'b1, 2'd1, 2'd3, 2'd2, 32'h600, 32'h700, 3);
        run_op(1'b1, 1'b1, 2'd3, 2'd1, 2'd1, 32'hA00, 32'hB00, 1);
        // R8: zero count
        run_op(1'b0, 1'b1, 2'd1, 2'd1, 2'd0, 32'h900, 32'h0, 0);

        summary();
    end
endmodule